// File: doc/BRIEF.md
# Scan Test Sequencer with Split Input/Output Scan Registers

This block places a small combinational circuit between two 4-bit banks of mux-based scan cells and adds a sequencer that runs the full scan test procedure by itself. When a start strobe arrives, the sequencer raises the test-mode select. This turns both banks into shift registers. A tester then clocks the first four bits of a vector into the input bank through the serial input, while it holds the fifth bit steady on the controllable primary input. The sequencer then drops the select for exactly one cycle. In that cycle the output bank captures what the circuit computes from the input bank and the primary input. After that the select goes high again.

Scan-out of a response overlaps with scan-in of the next vector. While the next vector's four bits enter the input bank, the previous response leaves the output bank on the serial output, most significant bit first. After the last vector, four drain cycles empty the output bank. One cycle later a done flag pulses. The default run length is two vectors. A typical run applies 01100 and then 11011.

Top module: `scan_seq_ctrl`

## Requirements
- R1: While reset is low and after reset, `test_mode`, `done` and `scan_out` are 0. The block then stays in normal mode (`test_mode` = 0) until a `start` pulse arrives.
- R2: While `test_mode` is 1, the input bank shifts `scan_in` into bit 0 and moves each bit up by one place. After four shifts, the first bit received sits in bit 3. The output bank shifts toward bit 3, fills bit 0 with 0, and `scan_out` always shows bit 3.
- R3: While `test_mode` is 0, the input bank holds its value. The output bank loads y[i] = x[i] XOR (x[(i+1) mod 4] AND (x[(i+2) mod 4] OR p)), where x is the input bank and p is `prim_in`.
- R4: A `start` seen in idle makes `test_mode` 1 from the next cycle. From then on, each vector takes exactly 4 cycles with `test_mode` 1 followed by exactly 1 capture cycle with `test_mode` 0. This repeats for NUM_VEC vectors (default 2).
- R5: A vector is 5 bits b4..b0. Bits b4, b3, b2, b1 are presented on `scan_in` in the first through fourth shift cycles. Bit b0 must be on `prim_in` at the capture edge. `prim_in` has no effect during the shift cycles.
- R6: The response of vector v leaves on `scan_out` as y3, y2, y1, y0 during the 4 shift cycles that follow its capture. After the last vector these are 4 drain cycles with `test_mode` 1.
- R7: `done` is 1 for exactly one cycle: the cycle after the last drain cycle. During that cycle `test_mode` is 0. The block then returns to idle.
- R8: A `start` pulse that arrives while a run is in progress is ignored and does not change the run's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a run of NUM_VEC vectors when idle |
| scan_in | input | 1 | Serial test data into the input bank |
| prim_in | input | 1 | Controllable primary input, held by the tester |
| scan_out | output | 1 | Serial response from the output bank |
| test_mode | output | 1 | Cell select: 1 shift, 0 capture |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
Counted from the clock edge that registers `start`, `test_mode` rises at once. The four vector bits are taken at edges 2 through 5. Capture happens at edge 6. The first response bit is on `scan_out` in the cycle after the capture edge, and the following bits come one per cycle after it. `done` is high in the fifth cycle after the last capture. The bench drives inputs and samples outputs on the falling edge. It keeps its own phase counters per vector, so every check falls in the cycle where its result is due. Runs include changes on `prim_in` during shifting and a `start` pulse in the middle of a run.

// File: rtl/scan_seq_pkg.sv
// Package: shared sequencer state type for the scan test block.
package scan_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_CAPTURE,
        ST_DRAIN,
        ST_FINISH
    } seq_state_t;
endpackage

// File: rtl/scan_cell.sv
// Module: scan_cell
// A flip-flop whose D input comes from a 2:1 mux. The mux passes func_d in
// normal mode and scan_d in test mode.
// Assumes: synchronous active-low reset that clears the cell.
module scan_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic test_mode,
    input  logic func_d,
    input  logic scan_d,
    output logic q
);
    // Select the D source and register it.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= test_mode ? scan_d : func_d;
    end
endmodule

// File: rtl/scan_bank.sv
// Module: scan_bank
// LEN scan cells chained from bit 0 up to bit LEN-1. In test mode, chain_in
// enters bit 0. In normal mode every cell loads its own func_d bit.
// Assumes: the caller takes the serial output from q[LEN-1].
module scan_bank #(
    parameter int LEN = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           test_mode,
    input  logic           chain_in,
    input  logic [LEN-1:0] func_d,
    output logic [LEN-1:0] q
);
    logic [LEN:0] link;

    // Serial path: the chain input feeds cell 0, each cell feeds the next.
    assign link[0] = chain_in;

    for (genvar i = 0; i < LEN; i++) begin : g_cell
        assign link[i+1] = q[i];
        scan_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .test_mode(test_mode),
            .func_d   (func_d[i]),
            .scan_d   (link[i]),
            .q        (q[i])
        );
    end
endmodule

// File: rtl/scan_cut.sv
// Module: scan_cut
// The combinational circuit under test:
// y[i] = x[i] ^ (x[i+1] & (x[i+2] | p)), indices taken mod N.
// Assumes: N >= 3, so that the three terms use distinct bits.
module scan_cut #(
    parameter int N = 4
) (
    input  logic [N-1:0] x,
    input  logic         p,
    output logic [N-1:0] y
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        localparam int J = (i + 1) % N;
        localparam int K = (i + 2) % N;
        // One output bit from three neighbouring inputs and the primary input.
        assign y[i] = x[i] ^ (x[J] & (x[K] | p));
    end
endmodule

// File: rtl/scan_seq_fsm.sv
// Module: scan_seq_fsm
// Sequencer. Per vector it runs LEN shift cycles and then one capture cycle.
// After the last vector it runs LEN drain cycles and then a one-cycle finish.
// Assumes: start is ignored outside idle. NUM_VEC >= 1, LEN >= 2.
module scan_seq_fsm
    import scan_seq_pkg::*;
#(
    parameter int LEN     = 4,
    parameter int NUM_VEC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic test_mode,
    output logic busy,
    output logic done
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(LEN - 1);
    localparam logic [VW-1:0] LAST_VEC = VW'(NUM_VEC - 1);

    seq_state_t    state_q;
    logic [CW-1:0] bit_q;
    logic [VW-1:0] vec_q;

    // State, bit counter and vector counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            vec_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    bit_q <= '0;
                    vec_q <= '0;
                    if (start) state_q <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (bit_q == LAST_BIT) begin
                        bit_q   <= '0;
                        state_q <= ST_CAPTURE;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                    end
                end
                ST_CAPTURE: begin
                    if (vec_q == LAST_VEC) begin
                        state_q <= ST_DRAIN;
                    end else begin
                        vec_q   <= vec_q + 1'b1;
                        state_q <= ST_SHIFT;
                    end
                end
                ST_DRAIN: begin
                    if (bit_q == LAST_BIT) begin
                        bit_q   <= '0;
                        state_q <= ST_FINISH;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                    end
                end
                ST_FINISH: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Decode the outputs from the state.
    always_comb begin
        test_mode = (state_q == ST_SHIFT) || (state_q == ST_DRAIN);
        busy      = (state_q == ST_SHIFT) || (state_q == ST_DRAIN) ||
                    (state_q == ST_CAPTURE);
        done      = (state_q == ST_FINISH);
    end
endmodule

// File: rtl/scan_seq_ctrl.sv
// Module: scan_seq_ctrl (top)
// An input scan bank, the circuit under test and an output scan bank, run by
// the sequencer. The two banks shift in parallel under one select, so a new
// vector enters while the previous response leaves.
// Assumes: the tester holds the primary-input bit on prim_in at the capture
// edge. In normal mode the input bank holds, because its functional source
// is outside this block.
module scan_seq_ctrl #(
    parameter int CHAIN_LEN = 4,
    parameter int NUM_VEC   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic scan_in,
    input  logic prim_in,
    output logic scan_out,
    output logic test_mode,
    output logic done
);
    logic                 busy;
    logic [CHAIN_LEN-1:0] in_q;
    logic [CHAIN_LEN-1:0] out_q;
    logic [CHAIN_LEN-1:0] cut_y;

    scan_seq_fsm #(.LEN(CHAIN_LEN), .NUM_VEC(NUM_VEC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .test_mode(test_mode),
        .busy     (busy),
        .done     (done)
    );

    scan_bank #(.LEN(CHAIN_LEN)) u_in_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .test_mode(test_mode),
        .chain_in (scan_in),
        .func_d   (in_q),
        .q        (in_q)
    );

    scan_cut #(.N(CHAIN_LEN)) u_cut (
        .x(in_q),
        .p(prim_in),
        .y(cut_y)
    );

    scan_bank #(.LEN(CHAIN_LEN)) u_out_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .test_mode(test_mode),
        .chain_in (1'b0),
        .func_d   (cut_y),
        .q        (out_q)
    );

    // The serial response leaves from the top cell of the output bank.
    assign scan_out = out_q[CHAIN_LEN-1];
endmodule

// File: rtl/scan_seq_chk.sv
// Module: scan_seq_chk
// Temporal checks on the scan sequencer, bound into scan_seq_ctrl.
// Assumes: synchronous active-low reset.
module scan_seq_chk #(
    parameter int LEN = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           test_mode,
    input logic           busy,
    input logic           done,
    input logic           scan_in,
    input logic [LEN-1:0] in_q,
    input logic [LEN-1:0] out_q
);
    logic [7:0] run_q;

    // Count the consecutive preceding cycles that had test_mode high (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n)              run_q <= '0;
        else if (!test_mode)     run_q <= '0;
        else if (run_q != 8'hFF) run_q <= run_q + 1'b1;
    end

    a_r2_in_shift: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |=> in_q == {$past(in_q[LEN-2:0]), $past(scan_in)});
    a_r2_out_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |=> out_q[0] == 1'b0);
    a_r3_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |=> in_q == $past(in_q));
    a_r4_shift_bound: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> run_q < 8'(LEN));
    a_r4_full_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !test_mode) |-> run_q == 8'(LEN));
    a_r4_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !test_mode) |=> test_mode);
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_done_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!test_mode && run_q == 8'(LEN)));
endmodule

bind scan_seq_ctrl scan_seq_chk #(.LEN(CHAIN_LEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .test_mode(test_mode),
    .busy     (busy),
    .done     (done),
    .scan_in  (scan_in),
    .in_q     (in_q),
    .out_q    (out_q)
);

// File: tb/scan_seq_ctrl_test.sv
`timescale 1ns/1ps
// Bench for scan_seq_ctrl: per-vector phase counters, checks on every falling edge.
module scan_seq_ctrl_test;
    logic clk = 1'b0;
    logic rst_n, start, scan_in, prim_in;
    logic scan_out, test_mode, done;
    int   checks = 0;
    int   fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    scan_seq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .start(start), .scan_in(scan_in),
        .prim_in(prim_in), .scan_out(scan_out), .test_mode(test_mode), .done(done)
    );

    // Response model from R3: x[3] is the first bit shifted in.
    function automatic logic [3:0] resp(input logic [3:0] x, input logic p);
        logic [3:0] y;
        for (int i = 0; i < 4; i++)
            y[i] = x[i] ^ (x[(i+1)%4] & (x[(i+2)%4] | p));
        return y;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // One run of two vectors. Optionally wiggles prim_in during shifting
    // and pokes start mid-run.
    task automatic run_pair(input logic [4:0] va, input logic [4:0] vb,
                            input bit wiggle, input bit poke);
        logic [4:0] v [2];
        logic [3:0] prev;
        v[0] = va; v[1] = vb; prev = '0;
        @(negedge clk);
        chk("R1 idle test_mode", test_mode, 1'b0);
        chk("R7 idle done", done, 1'b0);
        start = 1'b1;
        @(negedge clk);
        for (int vi = 0; vi < 2; vi++) begin
            for (int k = 0; k < 4; k++) begin
                chk("R4 shift test_mode", test_mode, 1'b1);
                chk("R7 done low in shift", done, 1'b0);
                if (vi > 0) chk("R6 overlapped response", scan_out, prev[3-k]);
                scan_in = v[vi][4-k];
                prim_in = (wiggle && k < 3) ? ~v[vi][0] : v[vi][0];  // R5
                start   = poke && (k == 1);                          // R8
                @(negedge clk);
            end
            chk("R4 capture test_mode", test_mode, 1'b0);
            start = poke;                                            // R8
            prev  = resp(v[vi][4:1], v[vi][0]);
            @(negedge clk);
        end
        start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk("R6 drain test_mode", test_mode, 1'b1);
            chk("R6 drained response", scan_out, prev[3-k]);
            chk("R7 done low in drain", done, 1'b0);
            scan_in = k[0];
            @(negedge clk);
        end
        chk("R7 done pulse", done, 1'b1);
        chk("R7 test_mode at done", test_mode, 1'b0);
        @(negedge clk);
        chk("R7 done single cycle", done, 1'b0);
        chk("R1 back to normal mode", test_mode, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; scan_in = 1'b0; prim_in = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset test_mode", test_mode, 1'b0);
        chk("R1 reset done", done, 1'b0);
        chk("R1 reset scan_out", scan_out, 1'b0);
        rst_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk("R1 idle without start", test_mode, 1'b0);
        end
        run_pair(5'b01100, 5'b11011, 1'b0, 1'b0);   // R2 R3 R4 R5 R6
        run_pair(5'b10101, 5'b00111, 1'b1, 1'b1);   // R5 prim_in ignored, R8 start ignored
        run_pair(5'b11110, 5'b00001, 1'b1, 1'b0);
        run_pair(5'b10000, 5'b01111, 1'b0, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule